// File: doc/BRIEF.md
# Dual Pseudo-Noise Authentication Tag Generator

This block turns two 16-bit seed words into an authentication tag of 16, 32, 64, 128 or 256 bits. Each seed is loaded into its own 16-stage Fibonacci shift register. Both registers then step once per clock. The two serial outputs are combined with XOR to form a keystream bit. Every keystream bit goes out on a serial port as soon as it exists, and it is also written into a tag buffer. When the selected number of bits has been produced, the buffer is presented as a tag word. In that word the bit positions are reordered by reversing the binary index within the selected length.

The seeds are supplied as ready binary words. One example is a word-derived seed of decimal 317 (16'h013D). Another is a character-derived digit string 1467 packed as four BCD nibbles (16'h1467). A caller pulses `start` together with the seeds and the length select. It then takes the keystream from `bit_out` while `bit_valid` is high, and the permuted tag from `tag_word` when `done` pulses.

Top module: `tag_auth_gen`

## Requirements
- R1: While `rst` is high, and in the first idle cycle after it, `busy`, `bit_valid`, `done` and `bit_out` are 0 and `tag_word` is all zero.
- R2: A seed equal to 16'h0000 is replaced by 16'h0001 when it is loaded. Any other seed is loaded unchanged.
- R3: Each generator shifts left once per busy cycle, and its serial output is its current bit 15. The feedback entering bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10, which is the polynomial x^16+x^14+x^13+x^11+1. The first serial bit is the MSB of the loaded seed.
- R4: `bit_out` is the XOR of the two generators' serial outputs. It is valid, with `bit_valid` high, for exactly L consecutive cycles that begin in the cycle after the accepted start.
- R5: `len_sel` selects L as follows: 0→16, 1→32, 2→64, 3→128, 4→256. Values 5, 6 and 7 also give 256. The value is captured at start.
- R6: With keystream bits c[0..L-1] in serial order and w = log2(L), `tag_word[i]` = c[bitrev_w(i)] for i < L. Bits L..255 are 0.
- R7: `done` is high for exactly one cycle, the cycle after the last valid bit. `busy` is low in that cycle.
- R8: A `start` that arrives while `busy` is high is ignored. The keystream, the length and the timing of `done` continue unchanged.
- R9: `tag_word` holds its value after `done` until the next accepted start.
- R10: A `start` in the `done` cycle is accepted. Its first bit appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a tag (accepted only when not busy) |
| seed_a | input | 16 | Seed for the first generator |
| seed_b | input | 16 | Seed for the second generator |
| len_sel | input | 3 | Tag length code |
| bit_out | output | 1 | Serial keystream bit |
| bit_valid | output | 1 | `bit_out` is valid |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle completion pulse |
| tag_word | output | 256 | Permuted tag, LSB-aligned |

## Verification
A start sampled at clock edge k places keystream bit j in the cycle after edge k+j, for j from 0 to L-1. The `done` pulse, the final `tag_word`, and `busy` going low all fall in the cycle after edge k+L. The bench drives inputs on falling edges and samples on falling edges. It therefore compares serial bit j, then `done` and the word, at exactly those cycles. It also checks for the absence of `done` in every cycle before that point and after it. Starts injected in the middle of a run are checked by comparing against the stream of the original seeds.

// File: rtl/tag_gen_pkg.sv
package tag_gen_pkg;

    localparam int unsigned SEED_W  = 16;
    localparam int unsigned MAX_LEN = 256;
    localparam int unsigned IDX_W   = $clog2(MAX_LEN);
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned MIN_LG  = 4;

    // feedback taps for x^16+x^14+x^13+x^11+1 (bits 15,13,12,10)
    localparam logic [SEED_W-1:0] FB_TAPS = 16'b1011_0100_0000_0000;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_e;

    typedef struct packed {
        logic [SEED_W-1:0] a;
        logic [SEED_W-1:0] b;
    } seed_pair_t;

    function automatic logic [SEED_W-1:0] seed_fix(input logic [SEED_W-1:0] s);
        return (s == '0) ? SEED_W'(1) : s;
    endfunction

    // log2 of the selected tag length
    function automatic int unsigned len_log2(input logic [SEL_W-1:0] sel);
        int unsigned lg;
        lg = MIN_LG + int'(sel);
        if (lg > IDX_W) lg = IDX_W;
        return lg;
    endfunction

    function automatic logic [IDX_W:0] len_of(input logic [SEL_W-1:0] sel);
        return (IDX_W+1)'(1) << len_log2(sel);
    endfunction

    function automatic logic [IDX_W-1:0] last_index(input logic [SEL_W-1:0] sel);
        logic [IDX_W:0] l;
        l = len_of(sel) - 1'b1;
        return l[IDX_W-1:0];
    endfunction

    // reverse the low w bits of idx; upper bits become zero
    function automatic logic [IDX_W-1:0] bit_rev(input logic [IDX_W-1:0] idx,
                                                 input int unsigned w);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int k = 0; k < int'(IDX_W); k++) begin
            if (k < int'(w)) r[k] = idx[int'(w) - 1 - k];
        end
        return r;
    endfunction

endpackage

// File: rtl/pn_shift_reg.sv
module pn_shift_reg
    import tag_gen_pkg::*;
#(
    parameter int unsigned W = SEED_W,
    parameter logic [W-1:0] TAPS = FB_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed_in,
    output logic         serial_o
);

    logic [W-1:0] state_q;
    logic         fb;

    assign fb       = ^(state_q & TAPS);
    assign serial_o = state_q[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= seed_in;
        end else if (step) begin
            state_q <= {state_q[W-2:0], fb};
        end
    end

    // R2: a loaded or stepped register is never all-zero
    a_r2_never_locked: assert property (@(posedge clk) disable iff (rst)
        (load || step) |=> (state_q != '0));

endmodule

// File: rtl/tag_bit_store.sv
module tag_bit_store
    import tag_gen_pkg::*;
#(
    parameter int unsigned DEPTH = MAX_LEN,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic             wr_bit,
    output logic [DEPTH-1:0] bits_o
);

    generate
        for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cell
            logic cell_q;
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    cell_q <= 1'b0;
                end else if (wr_en && (wr_idx == AW'(g))) begin
                    cell_q <= wr_bit;
                end
            end
            assign bits_o[g] = cell_q;
        end
    endgenerate

    // R9: with no write and no clear, the stored tag does not move
    a_r9_store_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !clear) |=> $stable(bits_o));

endmodule

// File: rtl/tag_reorder.sv
module tag_reorder
    import tag_gen_pkg::*;
(
    input  logic [MAX_LEN-1:0] raw_bits,
    input  logic [SEL_W-1:0]   sel,
    output logic [MAX_LEN-1:0] tag_o
);

    logic [IDX_W:0] len;
    int unsigned    lg;

    assign len = len_of(sel);
    assign lg  = len_log2(sel);

    always_comb begin
        tag_o = '0;
        for (int i = 0; i < int'(MAX_LEN); i++) begin
            if ((IDX_W+1)'(i) < len) begin
                tag_o[i] = raw_bits[bit_rev(IDX_W'(i), lg)];
            end
        end
    end

endmodule

// File: rtl/tag_auth_gen.sv
module tag_auth_gen
    import tag_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [15:0]        seed_a,
    input  logic [15:0]        seed_b,
    input  logic [2:0]         len_sel,
    output logic               bit_out,
    output logic               bit_valid,
    output logic               busy,
    output logic               done,
    output logic [255:0]       tag_word
);

    gen_state_e       state_q;
    logic [IDX_W-1:0] cnt_q;
    logic [SEL_W-1:0] len_q;
    logic             done_q;
    logic             accept;
    logic             running;
    seed_pair_t       seeds;
    logic             ser_a, ser_b;
    logic [MAX_LEN-1:0] raw_bits;

    assign running = (state_q == ST_RUN);
    assign accept  = start && !running;
    assign seeds   = '{a: seed_fix(seed_a), b: seed_fix(seed_b)};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_RUN;
                cnt_q   <= '0;
                len_q   <= len_sel;
            end else if (running) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == last_index(len_q)) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    pn_shift_reg #(.W(SEED_W), .TAPS(FB_TAPS)) u_pn_a (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step     (running),
        .seed_in  (seeds.a),
        .serial_o (ser_a)
    );

    pn_shift_reg #(.W(SEED_W), .TAPS(FB_TAPS)) u_pn_b (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step     (running),
        .seed_in  (seeds.b),
        .serial_o (ser_b)
    );

    assign bit_out   = running & (ser_a ^ ser_b);
    assign bit_valid = running;
    assign busy      = running;
    assign done      = done_q;

    tag_bit_store #(.DEPTH(MAX_LEN)) u_store (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .wr_en  (running),
        .wr_idx (cnt_q),
        .wr_bit (ser_a ^ ser_b),
        .bits_o (raw_bits)
    );

    tag_reorder u_reorder (
        .raw_bits (raw_bits),
        .sel      (len_q),
        .tag_o    (tag_word)
    );

    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: completion follows a busy cycle and is not itself busy
    a_r7_done_after_run: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && !busy));

    // R8: start during a run changes neither the length nor the count progression
    a_r8_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start && (cnt_q != last_index(len_q))) |=>
            ($stable(len_q) && busy && (cnt_q == $past(cnt_q) + 1'b1)));

    // R4: index never passes the selected length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= last_index(len_q)));

    // R10: a start seen in the done cycle begins a new run
    a_r10_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> busy);

endmodule

// File: tb/tag_auth_gen_tb.sv
module tag_auth_gen_tb;

    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [15:0]  seed_a, seed_b;
    logic [2:0]   len_sel;
    logic         bit_out, bit_valid, busy, done;
    logic [255:0] tag_word;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    logic [255:0] last_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_auth_gen u_dut (
        .clk(clk), .rst(rst), .start(start), .seed_a(seed_a), .seed_b(seed_b),
        .len_sel(len_sel), .bit_out(bit_out), .bit_valid(bit_valid),
        .busy(busy), .done(done), .tag_word(tag_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] m_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int m_len(input logic [2:0] sel);
        return (sel >= 3'd4) ? 256 : (16 << sel);
    endfunction

    function automatic int m_lg(input logic [2:0] sel);
        return (sel >= 3'd4) ? 8 : (4 + int'(sel));
    endfunction

    function automatic logic [255:0] m_stream(input logic [15:0] a, input logic [15:0] b,
                                              input int n);
        logic [255:0] c;
        logic [15:0] sa, sb;
        c = '0;
        sa = (a == 16'h0) ? 16'h0001 : a;
        sb = (b == 16'h0) ? 16'h0001 : b;
        for (int j = 0; j < n; j++) begin
            c[j] = sa[15] ^ sb[15];
            sa = m_step(sa);
            sb = m_step(sb);
        end
        return c;
    endfunction

    function automatic logic [255:0] m_tag(input logic [255:0] c, input logic [2:0] sel);
        logic [255:0] t;
        int w, r;
        t = '0;
        w = m_lg(sel);
        for (int i = 0; i < m_len(sel); i++) begin
            r = 0;
            for (int k = 0; k < w; k++) r |= ((i >> (w - 1 - k)) & 1) << k;
            t[i] = c[r];
        end
        return t;
    endfunction

    // Called on a falling edge; drives start there, returns in the done cycle.
    task automatic run_case(input logic [15:0] a, input logic [15:0] b,
                            input logic [2:0] sel, input int inject_at);
        logic [255:0] c, t;
        int n;
        n = m_len(sel);
        c = m_stream(a, b, n);
        t = m_tag(c, sel);
        seed_a = a; seed_b = b; len_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < n; j++) begin
            chk(bit_valid && busy && !done, "R4", "valid window", {253'd0, bit_valid, busy, done}, 256'd6);
            chk(bit_out == c[j], (j < 16) ? "R3" : "R4", $sformatf("bit %0d", j), 256'(bit_out), 256'(c[j]));
            if (j == inject_at) begin
                start = 1'b1; seed_a = ~a; seed_b = a ^ 16'h5A5A; len_sel = 3'd0;
            end else begin
                start = 1'b0; seed_a = a; seed_b = b; len_sel = sel;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done && !busy && !bit_valid, "R7", "done pulse", {253'd0, done, busy, bit_valid}, 256'd4);
        chk(tag_word == t, (inject_at >= 0) ? "R8" : "R6", "tag word", tag_word, t);
        last_tag = t;
    endtask

    task automatic hold_check(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            chk(!done && !busy && !bit_valid, "R7", "idle after done", {253'd0, done, busy, bit_valid}, 256'd0);
            chk(tag_word == last_tag, "R9", "tag held", tag_word, last_tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; seed_a = '0; seed_b = '0; len_sel = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !bit_valid && !done && !bit_out, "R1", "reset outputs",
            {252'd0, busy, bit_valid, done, bit_out}, 256'd0);
        chk(tag_word == '0, "R1", "reset tag", tag_word, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && tag_word == '0, "R1", "idle after reset", {254'd0, busy, done}, 256'd0);

        // worked seeds: 317 and BCD 1467, every length code (R5)
        for (int s = 0; s < 8; s++) begin
            run_case(16'h013D, 16'h1467, 3'(s), -1);
            hold_check(2);
        end
        // zero seeds are replaced by 0001 (R2)
        run_case(16'h0000, 16'hACE1, 3'd0, -1);
        hold_check(1);
        run_case(16'h0000, 16'h0000, 3'd1, -1);
        hold_check(1);
        // start while busy is ignored (R8)
        run_case(16'hBEEF, 16'h1234, 3'd1, 5);
        hold_check(1);
        // back-to-back: next start in the done cycle (R10)
        run_case(16'h8001, 16'h7FFE, 3'd0, -1);
        run_case(16'h4321, 16'h00FF, 3'd2, -1);
        run_case(16'hFFFF, 16'h0001, 3'd0, -1);
        hold_check(2);
        // random cases
        for (int r = 0; r < 12; r++) begin
            logic [15:0] ra, rb;
            logic [2:0]  rs;
            int inj;
            ra = 16'($urandom); rb = 16'($urandom); rs = 3'($urandom % 8);
            inj = ($urandom % 3 == 0) ? int'($urandom % 15) : -1;
            run_case(ra, rb, rs, inj);
            hold_check(1 + int'($urandom % 3));
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule